// File: doc/BRIEF.md
# ADC Control and Power Sequencer

This block is the digital front end of a successive-approximation converter. A 32-bit control word, written over a simple write strobe and read back at all times, holds three things: a sample clock divide value, a low-power enable and a self-calibration request. From the system clock the block makes a single-cycle sample clock enable. It also decides when the analog core is powered and when a sample begins.

With low-power mode clear, the analog core stays powered and a trigger starts a sample at once. With low-power mode set, the core is unpowered while idle. A trigger powers the core up, and sampling waits for a fixed warm-up of divided-clock periods. A trigger that arrives during warm-up or conversion is held as a single pending request. That request starts the next sample directly, with no second warm-up.

Writing the calibration bit starts a calibration handshake with the analog core. The bit clears itself when the core reports completion. Until then the control word refuses every write, and triggers are dropped.

Top module: `adc_pwr_ctl`

## Requirements
- R1: Synchronous reset clears the control word to zero and leaves `sample_start` and `cal_start` low.
- R2: Bits 7:0 hold a divide value N. Once settled, `smp_clk_en` is high for one cycle out of every N+1, so N=0 makes it high every cycle.
- R3: Only bits 7:0, 10 and 30 are storage. All other bits read as zero, whatever is written to them.
- R4: With bit 10 clear, `ana_pwr_en` stays high from the first cycle after reset. A trigger shows `sample_start` in the cycle right after the trigger is sampled.
- R5: With bit 10 set and no conversion active or pending, `ana_pwr_en` is low.
- R6: With bit 10 set, a software or hardware trigger raises `ana_pwr_en` in the next cycle. `sample_start` follows only after exactly 15 `smp_clk_en` pulses have been seen during warm-up.
- R7: Triggers received during warm-up or conversion leave at most one pending request. That request starts a sample in the cycle after `conv_done`, with power kept on and no new warm-up.
- R8: Writing 1 to bit 30 stores the other fields from the same write, raises `ana_pwr_en` and pulses `cal_start` once. Bit 30 reads as 1 until `cal_done`, then reads as 0.
- R9: While bit 30 reads 1, writes have no effect on the control word. After it clears, writes are accepted again.
- R10: Triggers that arrive while calibration runs are discarded, and no sample follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Control word write strobe |
| bus_wdata | input | 32 | Control word write data |
| bus_rdata | output | 32 | Control word read data |
| sw_trig | input | 1 | Software conversion trigger, one-cycle pulse |
| hw_trig | input | 1 | Hardware conversion trigger, one-cycle pulse |
| smp_clk_en | output | 1 | Divided sample clock enable |
| ana_pwr_en | output | 1 | Analog core power enable |
| sample_start | output | 1 | Start-of-sample pulse to the analog core |
| conv_done | input | 1 | Conversion complete from the analog core |
| cal_start | output | 1 | Calibration start pulse to the analog core |
| cal_done | input | 1 | Calibration complete from the analog core |

## Verification
The bench counts divided-clock pulses between a low-power trigger and the start of sampling. A warm-up counted in system cycles, or one off by one, gives a count other than 15. It fires three triggers into a single low-power conversion: a queue deeper than one shows a third sample, and a design that re-enters warm-up shows a gap wider than one cycle after `conv_done`, or a power dip. During calibration it writes zeros and fires a trigger. A missing write lock corrupts the fields read back, and a queued trigger produces a sample once calibration ends.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  // control word layout; the positions are decoded by software
  localparam int CTL_W   = 32;
  localparam int LP_BIT  = 10;
  localparam int CAL_BIT = 30;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WARM,
    SQ_SAMPLE,
    SQ_CONV,
    SQ_CAL_GO,
    SQ_CAL_WAIT
  } seq_state_e;
endpackage

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_ctl_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  input  logic             cal_clr,
  output logic [DIV_W-1:0] div_q,
  output logic             lp_q,
  output logic             cal_q,
  output logic [CTL_W-1:0] rdata
);
  logic unused_bits;
  assign unused_bits = ^{wdata[CTL_W-1:DIV_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      lp_q  <= 1'b0;
      cal_q <= 1'b0;
    end else if (cal_q) begin
      // locked while calibrating; only completion may clear the bit
      if (cal_clr) cal_q <= 1'b0;
    end else if (wr_en) begin
      div_q <= wdata[DIV_W-1:0];
      lp_q  <= wdata[LP_BIT];
      cal_q <= wdata[CAL_BIT];
    end
  end

  always_comb begin
    rdata                = '0;
    rdata[DIV_W-1:0]     = div_q;
    rdata[LP_BIT]        = lp_q;
    rdata[CAL_BIT]       = cal_q;
  end
endmodule

// File: rtl/adc_ctl_clkdiv.sv
module adc_ctl_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  // reload from div on each tick, so a new divide value applies at the next reload
  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == '0)  cnt_q <= div;
    else                   cnt_q <= cnt_q - 1'b1;
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_ctl_pkg::*;
#(
  parameter int STARTUP_TICKS = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic lp,
  input  logic cal_req,
  input  logic trig,
  input  logic tick,
  input  logic conv_done,
  input  logic cal_done,
  output logic pwr_en,
  output logic sample_start,
  output logic cal_start,
  output logic cal_clr
);
  localparam int SU_W = $clog2(STARTUP_TICKS + 1);
  localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_TICKS - 1);

  seq_state_e      state_q, state_n;
  logic [SU_W-1:0] su_q, su_n;
  logic            pend_q, pend_n;
  logic            take;

  assign take = trig && !cal_req;

  always_comb begin
    state_n = state_q;
    su_n    = su_q;
    pend_n  = pend_q;
    cal_clr = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (cal_req) begin
          state_n = SQ_CAL_GO;
          pend_n  = 1'b0;
        end else if (trig || pend_q) begin
          pend_n = 1'b0;
          if (lp) begin
            state_n = SQ_WARM;
            su_n    = '0;
          end else begin
            state_n = SQ_SAMPLE;
          end
        end
      end
      SQ_WARM: begin
        if (take) pend_n = 1'b1;
        if (tick) begin
          if (su_q == SU_LAST) state_n = SQ_SAMPLE;
          else                 su_n    = su_q + 1'b1;
        end
      end
      SQ_SAMPLE: begin
        if (take) pend_n = 1'b1;
        state_n = SQ_CONV;
      end
      SQ_CONV: begin
        if (take) pend_n = 1'b1;
        if (conv_done) begin
          if ((pend_q || trig) && !cal_req) begin
            state_n = SQ_SAMPLE;
            pend_n  = 1'b0;
          end else begin
            state_n = SQ_IDLE;
          end
        end
      end
      SQ_CAL_GO: state_n = SQ_CAL_WAIT;
      SQ_CAL_WAIT: begin
        if (cal_done) begin
          state_n = SQ_IDLE;
          cal_clr = 1'b1;
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SQ_IDLE;
      su_q         <= '0;
      pend_q       <= 1'b0;
      pwr_en       <= 1'b0;
      sample_start <= 1'b0;
      cal_start    <= 1'b0;
    end else begin
      state_q      <= state_n;
      su_q         <= su_n;
      pend_q       <= pend_n;
      pwr_en       <= !lp || (state_n != SQ_IDLE);
      sample_start <= (state_n == SQ_SAMPLE);
      cal_start    <= (state_n == SQ_CAL_GO);
    end
  end
endmodule

// File: rtl/adc_pwr_ctl.sv
module adc_pwr_ctl
  import adc_ctl_pkg::*;
#(
  parameter int DIV_W         = 8,
  parameter int STARTUP_TICKS = 15
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        sw_trig,
  input  logic        hw_trig,
  output logic        smp_clk_en,
  output logic        ana_pwr_en,
  output logic        sample_start,
  input  logic        conv_done,
  output logic        cal_start,
  input  logic        cal_done
);
  logic [DIV_W-1:0] div;
  logic             lp, cal_bit, cal_clr;

  adc_ctl_regs #(.DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wdata(bus_wdata),
    .cal_clr(cal_clr), .div_q(div), .lp_q(lp), .cal_q(cal_bit),
    .rdata(bus_rdata)
  );

  adc_ctl_clkdiv #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst(rst), .div(div), .tick(smp_clk_en)
  );

  adc_ctl_seq #(.STARTUP_TICKS(STARTUP_TICKS)) seq_i (
    .clk(clk), .rst(rst), .lp(lp), .cal_req(cal_bit),
    .trig(sw_trig | hw_trig), .tick(smp_clk_en),
    .conv_done(conv_done), .cal_done(cal_done),
    .pwr_en(ana_pwr_en), .sample_start(sample_start),
    .cal_start(cal_start), .cal_clr(cal_clr)
  );
endmodule

// File: rtl/adc_pwr_ctl_chk.sv
module adc_pwr_ctl_chk (
  input logic        clk,
  input logic        rst,
  input logic [10:0] rd_low,
  input logic        rd_cal,
  input logic        ana_pwr_en,
  input logic        sample_start,
  input logic        cal_start,
  input logic        cal_done
);
  logic cal_run;

  always_ff @(posedge clk) begin
    if (rst)            cal_run <= 1'b0;
    else if (cal_start) cal_run <= 1'b1;
    else if (cal_done)  cal_run <= 1'b0;
  end

  // R4: full-power mode keeps the core powered
  a_r4_pwr_full_mode: assert property (@(posedge clk) disable iff (rst)
    !rd_low[10] |=> ana_pwr_en);

  // R6: a sample never starts on an unpowered core
  a_r6_pwr_at_sample: assert property (@(posedge clk) disable iff (rst)
    sample_start |-> ana_pwr_en);

  // R7: each sample start is a single-cycle pulse
  a_r7_sample_pulse: assert property (@(posedge clk) disable iff (rst)
    sample_start |=> !sample_start);

  // R8: calibration start only while the request bit reads set
  a_r8_cal_start_bit: assert property (@(posedge clk) disable iff (rst)
    cal_start |-> rd_cal);

  // R9: fields stay frozen while calibration is requested
  a_r9_write_lock: assert property (@(posedge clk) disable iff (rst)
    rd_cal |=> $stable(rd_low));

  // R10: no sample during a calibration handshake
  a_r10_no_sample_cal: assert property (@(posedge clk) disable iff (rst)
    cal_run |-> !sample_start);
endmodule

bind adc_pwr_ctl adc_pwr_ctl_chk chk_i (
  .clk(clk), .rst(rst), .rd_low(bus_rdata[10:0]), .rd_cal(bus_rdata[30]),
  .ana_pwr_en(ana_pwr_en), .sample_start(sample_start),
  .cal_start(cal_start), .cal_done(cal_done)
);

// File: tb/adc_pwr_ctl_tb_top.sv
`timescale 1ns/1ps
module adc_pwr_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_LAT   = 6;
  localparam int CAL_LAT    = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sw_trig = 1'b0;
  logic        hw_trig = 1'b0;
  logic        smp_clk_en, ana_pwr_en, sample_start, cal_start;
  logic        conv_done, cal_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pwr_ctl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sw_trig(sw_trig), .hw_trig(hw_trig),
    .smp_clk_en(smp_clk_en), .ana_pwr_en(ana_pwr_en),
    .sample_start(sample_start), .conv_done(conv_done),
    .cal_start(cal_start), .cal_done(cal_done)
  );

  // analog core stand-in: fixed-latency responses, driven just after each edge
  initial begin
    int cc = 0;
    int kc = 0;
    conv_done = 1'b0;
    cal_done  = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      conv_done = 1'b0;
      cal_done  = 1'b0;
      if (cc != 0) begin cc--; if (cc == 0) conv_done = 1'b1; end
      if (kc != 0) begin kc--; if (kc == 0) cal_done = 1'b1; end
      if (sample_start) cc = CONV_LAT;
      if (cal_start)    kc = CAL_LAT;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    chk("R1 sample_start idle", {31'b0, sample_start}, 32'h0);
    chk("R1 cal_start idle", {31'b0, cal_start}, 32'h0);
    @(negedge clk);
    chk("R4 power after reset", {31'b0, ana_pwr_en}, 32'h1);
  endtask

  task automatic t_reserved();
    wr(32'hBFFF_FFFF);
    chk("R3 reserved bits read zero", bus_rdata, 32'h0000_04FF);
    wr(32'h0);
    chk("R3 clear back", bus_rdata, 32'h0);
  endtask

  task automatic t_divider(input int n);
    int c = 0;
    int g = 0;
    wr(32'(n));
    repeat (3*(n+1)+3) @(negedge clk);
    while (!smp_clk_en && g < 600) begin @(negedge clk); g++; end
    do begin @(negedge clk); c++; end while (!smp_clk_en && c < 600);
    chk($sformatf("R2 tick period N=%0d", n), 32'(c), 32'(n+1));
  endtask

  task automatic t_full_power();
    bit drop = 1'b0;
    wr(32'h0000_0002);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!ana_pwr_en) drop = 1'b1;
    end
    chk("R4 power held while idle", {31'b0, drop}, 32'h0);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
    chk("R4 immediate sample", {31'b0, sample_start}, 32'h1);
    repeat (20) @(negedge clk);
    chk("R4 power after conversion", {31'b0, ana_pwr_en}, 32'h1);
  endtask

  task automatic t_lp_trigger(input bit use_hw);
    int ticks = 0;
    int g = 0;
    wr(32'h0000_0401);
    repeat (5) @(negedge clk);
    chk("R5 power off while idle", {31'b0, ana_pwr_en}, 32'h0);
    if (use_hw) hw_trig = 1'b1; else sw_trig = 1'b1;
    @(negedge clk);
    hw_trig = 1'b0; sw_trig = 1'b0;
    chk(use_hw ? "R6 power on hw trigger" : "R6 power on sw trigger",
        {31'b0, ana_pwr_en}, 32'h1);
    while (!sample_start && g < 500) begin
      if (smp_clk_en) ticks++;
      @(negedge clk);
      g++;
    end
    chk("R6 warm-up tick count", 32'(ticks), 32'd15);
    repeat (CONV_LAT + 5) @(negedge clk);
    chk("R5 power off after conversion", {31'b0, ana_pwr_en}, 32'h0);
  endtask

  task automatic t_backtoback();
    int n = 0;
    int last_done = -100;
    int gap = -1;
    bit drop = 1'b0;
    wr(32'h0000_0401);
    repeat (3) @(negedge clk);
    sw_trig = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sample_start) begin
        n++;
        if (n == 2) gap = i - last_done;
      end
      if (conv_done) last_done = i;
      if (n < 2 && !ana_pwr_en) drop = 1'b1;
      sw_trig = (i == 3) || (i == 5);
      hw_trig = (i == 4);
    end
    sw_trig = 1'b0; hw_trig = 1'b0;
    chk("R7 one pending request", 32'(n), 32'd2);
    chk("R7 no re-warm gap", 32'(gap), 32'd1);
    chk("R7 power held between samples", {31'b0, drop}, 32'h0);
    chk("R5 power off at end", {31'b0, ana_pwr_en}, 32'h0);
  endtask

  task automatic t_cal();
    int n_cal = 0;
    int n_smp = 0;
    bit in_cal = 1'b0;
    bit pwr_bad = 1'b0;
    bit cleared = 1'b0;
    logic [31:0] held = '0;
    wr(32'h4000_0405);
    chk("R8 fields stored with cal", bus_rdata, 32'h4000_0405);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (cal_start) begin n_cal++; in_cal = 1'b1; end
      if (sample_start) n_smp++;
      if (in_cal && bus_rdata[30] && !ana_pwr_en) pwr_bad = 1'b1;
      if (!bus_rdata[30]) cleared = 1'b1;
      if (i == 4) held = bus_rdata;
      bus_wr    = (i == 2);
      bus_wdata = (i == 2) ? 32'h0 : 32'h0;
      sw_trig   = (i == 5);
      hw_trig   = (i == 7);
    end
    sw_trig = 1'b0; hw_trig = 1'b0;
    chk("R8 one cal_start pulse", 32'(n_cal), 32'd1);
    chk("R8 power during calibration", {31'b0, pwr_bad}, 32'h0);
    chk("R9 write ignored during cal", held, 32'h4000_0405);
    chk("R8 cal bit self-clears", {31'b0, cleared}, 32'h1);
    chk("R9 fields kept after cal", bus_rdata, 32'h0000_0405);
    chk("R10 triggers in cal dropped", 32'(n_smp), 32'd0);
    chk("R10 power off after cal", {31'b0, ana_pwr_en}, 32'h0);
    wr(32'h0000_0003);
    chk("R9 writes accepted after cal", bus_rdata, 32'h0000_0003);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_reserved();
    t_divider(0);
    t_divider(3);
    t_divider(7);
    t_full_power();
    t_lp_trigger(1'b0);
    t_lp_trigger(1'b1);
    t_backtoback();
    t_cal();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule